// File: doc/BRIEF.md
# Burst SRAM Access Cycle Controller

This block sits at the control edge of a pipelined synchronous burst SRAM. On every rising clock edge it looks at the two address-status strobes, the chip enable and the two chip selects. It also looks at the burst-advance strobe and the write-request summary that the byte-write logic produces. From these it decides what kind of cycle is being requested. The cycle kinds are deselect, start of a read burst, start of a write burst, continuation with advance, and continuation that holds the current address.

From that decision it drives four strobes. The load strobe and the advance strobe go to the address sequencer. The read enable and the write enable go to the memory array.

A one-stage output pipeline tracks whether the previous cycle was a selected read. This makes read data appear on the pins one edge after its address. The output-driver enable combines that registered flag with three conditions: the asynchronous output-enable pin, the sleep input, and any write in the present cycle.

The two address strobes follow different rules. The processor-side strobe only counts while chip enable is asserted. The controller-side strobe is not gated by chip enable. A start through the processor strobe is always a read.

Top module: `bsram_cycle_ctrl`

## Requirements
- R1: The device counts as selected only when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0 together. A start in any other chip-select combination is not a burst start.
- R2: A cycle is a deselect in two cases: `ce_n`=1 with `adsc_n`=0, or `ce_n`=0 with either strobe low while not selected. A deselect asserts none of `addr_load`, `mem_rd_en` or `mem_wr_en`, and it ends any open burst.
- R3: While `ce_n`=1, `adsp_n` has no effect. With `adsc_n`=1 such a cycle is a burst continuation.
- R4: A selected cycle with `adsp_n`=0 asserts `addr_load` and `mem_rd_en`, whatever the value of `wr_req`.
- R5: A selected cycle with `adsp_n`=1 and `adsc_n`=0 asserts `addr_load`. It also asserts `mem_wr_en` when `wr_req`=1, and `mem_rd_en` otherwise.
- R6: With both strobes high and a burst open, `adv_n`=0 pulses `addr_adv` and `adv_n`=1 leaves it low. `wr_req` picks `mem_wr_en` or `mem_rd_en` for that beat. After reset or a deselect no burst is open, and a continuation then asserts no strobe.
- R7: `out_drv_en` rises in the clock period after a cycle that asserted `mem_rd_en`.
- R8: In the clock period that follows a deselect cycle, `out_drv_en` is 0.
- R9: `oe_n`=1 forces `out_drv_en` to 0 in the same cycle, without waiting for a clock edge.
- R10: In any cycle that asserts `mem_wr_en`, `out_drv_en` is 0.
- R11: While `sleep`=1, all strobes and `out_drv_en` are 0 and the internal state holds. When `sleep` falls, the burst and pipeline state are as they were before sleep.
- R12: `cyc_kind` reports the decoded cycle whatever the value of `sleep`: 0 deselect, 1 begin read, 2 begin write, 3 continue with advance, 4 continue with hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by `ce_n` |
| adsc_n | input | 1 | Controller-side address strobe, active low, not gated |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_req | input | 1 | Write requested this cycle (global or qualified byte write) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep; freezes all state |
| addr_load | output | 1 | Load the external address into the sequencer |
| addr_adv | output | 1 | Step the sequencer to the next burst address |
| mem_rd_en | output | 1 | Array read this cycle |
| mem_wr_en | output | 1 | Array write this cycle |
| out_drv_en | output | 1 | Data output driver enable |
| cyc_kind | output | 3 | Decoded cycle kind |

## Verification
The block holds only two bits of state: the open-burst flag and the pending-read flag. Either can be wrong without changing the cycle decode.

A stale open-burst flag shows up on the first continuation cycle after a deselect or after reset. In that cycle `addr_adv` or a memory enable is asserted when it should not be. A wrong pending-read flag shows up in the very next clock period as a wrong `out_drv_en`. The single-cycle deselect and the sleep freeze are the patterns that expose it.

Because every output is compared on every cycle against a behavioural model, a fault shows up within one cycle of the stimulus that touches it.

// File: rtl/bsram_cycle_pkg.sv
package bsram_cycle_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_DESEL    = 3'd0,
    KIND_BEGIN_RD = 3'd1,
    KIND_BEGIN_WR = 3'd2,
    KIND_CONT_ADV = 3'd3,
    KIND_CONT_HLD = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic desel;
    logic begin_rd;
    logic begin_wr;
    logic cont;
    logic adv;
  } cyc_dec_t;
endpackage

// File: rtl/bsram_cycle_decode.sv
module bsram_cycle_decode
  import bsram_cycle_pkg::*;
(
  input  logic      adsp_n,
  input  logic      adsc_n,
  input  logic      ce_n,
  input  logic      cs_hi,
  input  logic      cs_lo_n,
  input  logic      adv_n,
  input  logic      wr_req,
  output cyc_dec_t  dec,
  output cyc_kind_e kind
);
  logic selected;
  logic proc_start;
  logic ctrl_start;
  logic any_start;

  always_comb begin
    selected   = ~ce_n & cs_hi & ~cs_lo_n;
    proc_start = ~adsp_n & ~ce_n;
    ctrl_start = ~adsc_n;
    any_start  = proc_start | ctrl_start;

    dec.desel    = any_start & ~selected;
    dec.begin_rd = selected & (proc_start | (ctrl_start & ~wr_req));
    dec.begin_wr = selected & ~proc_start & ctrl_start & wr_req;
    dec.cont     = ~any_start;
    dec.adv      = ~any_start & ~adv_n;

    if (dec.desel)         kind = KIND_DESEL;
    else if (dec.begin_rd) kind = KIND_BEGIN_RD;
    else if (dec.begin_wr) kind = KIND_BEGIN_WR;
    else if (dec.adv)      kind = KIND_CONT_ADV;
    else                   kind = KIND_CONT_HLD;
  end
endmodule

// File: rtl/bsram_burst_state.sv
module bsram_burst_state
  import bsram_cycle_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep,
  input  logic     wr_req,
  input  cyc_dec_t dec,
  output logic     rd_cyc,
  output logic     wr_cyc,
  output logic     addr_load,
  output logic     addr_adv,
  output logic     mem_rd_en,
  output logic     mem_wr_en
);
  logic open_q;
  logic open_d;
  logic open_en;

  always_comb begin
    rd_cyc = dec.begin_rd | (dec.cont & open_q & ~wr_req);
    wr_cyc = dec.begin_wr | (dec.cont & open_q & wr_req);

    addr_load = ~sleep & (dec.begin_rd | dec.begin_wr);
    addr_adv  = ~sleep & dec.adv & open_q;
    mem_rd_en = ~sleep & rd_cyc;
    mem_wr_en = ~sleep & wr_cyc;

    open_en = ~sleep;
    if (dec.desel)                        open_d = 1'b0;
    else if (dec.begin_rd | dec.begin_wr) open_d = 1'b1;
    else                                  open_d = open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (open_en) open_q <= open_d;
  end
endmodule

// File: rtl/bsram_out_pipe.sv
module bsram_out_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic rd_cyc,
  input  logic wr_cyc,
  input  logic oe_n,
  output logic out_drv_en
);
  logic rd_pend_q;
  logic rd_pend_d;
  logic pend_en;

  always_comb begin
    pend_en    = ~sleep;
    rd_pend_d  = rd_cyc;
    out_drv_en = rd_pend_q & ~sleep & ~oe_n & ~wr_cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_pend_q <= 1'b0;
    else if (pend_en) rd_pend_q <= rd_pend_d;
  end
endmodule

// File: rtl/bsram_cycle_ctrl.sv
module bsram_cycle_ctrl
  import bsram_cycle_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adv_n,
  input  logic              wr_req,
  input  logic              oe_n,
  input  logic              sleep,
  output logic              addr_load,
  output logic              addr_adv,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              out_drv_en,
  output logic [KIND_W-1:0] cyc_kind
);
  logic [RST_SYNC_STAGES-1:0] rst_sync_q;
  logic                       rst_core_n;
  cyc_dec_t                   dec;
  cyc_kind_e                  kind;
  logic                       rd_cyc;
  logic                       wr_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[RST_SYNC_STAGES-1];

  bsram_cycle_decode u_decode (
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .ce_n   (ce_n),
    .cs_hi  (cs_hi),
    .cs_lo_n(cs_lo_n),
    .adv_n  (adv_n),
    .wr_req (wr_req),
    .dec    (dec),
    .kind   (kind)
  );

  bsram_burst_state u_state (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sleep    (sleep),
    .wr_req   (wr_req),
    .dec      (dec),
    .rd_cyc   (rd_cyc),
    .wr_cyc   (wr_cyc),
    .addr_load(addr_load),
    .addr_adv (addr_adv),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en)
  );

  bsram_out_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sleep     (sleep),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .oe_n      (oe_n),
    .out_drv_en(out_drv_en)
  );

  assign cyc_kind = kind;
endmodule

// File: rtl/bsram_cycle_ctrl_chk.sv
module bsram_cycle_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adsp_n,
  input logic       adsc_n,
  input logic       ce_n,
  input logic       cs_hi,
  input logic       cs_lo_n,
  input logic       oe_n,
  input logic       sleep,
  input logic       addr_load,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic       out_drv_en,
  input logic [2:0] cyc_kind
);
  a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd0) |-> (!addr_load && !mem_rd_en && !mem_wr_en));

  a_r4_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce_n && cs_hi && !cs_lo_n && !sleep) |-> (addr_load && mem_rd_en && !mem_wr_en));

  a_r7_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (out_drv_en || oe_n || sleep || mem_wr_en));

  a_r8_single_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd0 && !sleep) |=> !out_drv_en);

  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !out_drv_en);

  a_r10_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !out_drv_en);

  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!addr_load && !mem_rd_en && !mem_wr_en && !out_drv_en));

  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
endmodule

bind bsram_cycle_ctrl bsram_cycle_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adsp_n    (adsp_n),
  .adsc_n    (adsc_n),
  .ce_n      (ce_n),
  .cs_hi     (cs_hi),
  .cs_lo_n   (cs_lo_n),
  .oe_n      (oe_n),
  .sleep     (sleep),
  .addr_load (addr_load),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .out_drv_en(out_drv_en),
  .cyc_kind  (cyc_kind)
);

// File: tb/bsram_cycle_ctrl_tb_top.sv
module bsram_cycle_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic adsp_n, adsc_n, ce_n, cs_hi, cs_lo_n, adv_n, wr_req, oe_n, sleep;
  logic addr_load, addr_adv, mem_rd_en, mem_wr_en, out_drv_en;
  logic [2:0] cyc_kind;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference state
  bit m_open = 0;
  bit m_pend = 0;

  always #10 clk = ~clk;

  bsram_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .ce_n(ce_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n), .wr_req(wr_req),
    .oe_n(oe_n), .sleep(sleep), .addr_load(addr_load), .addr_adv(addr_adv),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .out_drv_en(out_drv_en),
    .cyc_kind(cyc_kind)
  );

  task automatic cmp(input string req, input string nm, input int act, input int exp_v);
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp_v, $time);
    end
  endtask

  // One cycle: drive at falling edge, compare mid-low, update model at rising edge.
  task automatic step(input bit p, input bit c, input bit ce, input bit s0, input bit s1,
                      input bit av, input bit wr, input bit oe, input bit zz, input string req);
    bit sel, pst, cst, dsl, brd, bwr, cont, rd, wrc;
    int kind;
    @(negedge clk);
    adsp_n = p; adsc_n = c; ce_n = ce; cs_hi = s0; cs_lo_n = s1;
    adv_n = av; wr_req = wr; oe_n = oe; sleep = zz;
    #5;
    sel  = !ce && s0 && !s1;
    pst  = !p && !ce;
    cst  = !c;
    dsl  = (pst || cst) && !sel;
    brd  = sel && (pst || (cst && !wr));
    bwr  = sel && !pst && cst && wr;
    cont = !pst && !cst;
    rd   = brd || (cont && m_open && !wr);
    wrc  = bwr || (cont && m_open && wr);
    kind = dsl ? 0 : brd ? 1 : bwr ? 2 : (cont && !av) ? 3 : 4;
    n_vec++;
    cmp(req, "cyc_kind",   int'(cyc_kind),   kind);
    cmp(req, "addr_load",  int'(addr_load),  int'(!zz && (brd || bwr)));
    cmp(req, "addr_adv",   int'(addr_adv),   int'(!zz && cont && !av && m_open));
    cmp(req, "mem_rd_en",  int'(mem_rd_en),  int'(!zz && rd));
    cmp(req, "mem_wr_en",  int'(mem_wr_en),  int'(!zz && wrc));
    cmp(req, "out_drv_en", int'(out_drv_en), int'(m_pend && !zz && !oe && !wrc));
    @(posedge clk);
    if (!zz) begin
      if (dsl) m_open = 0;
      else if (brd || bwr) m_open = 1;
      m_pend = rd;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    end
    $finish;
  end

  initial begin
    rst_n = 0;
    adsp_n = 1; adsc_n = 1; ce_n = 1; cs_hi = 0; cs_lo_n = 1;
    adv_n = 1; wr_req = 0; oe_n = 0; sleep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    // reset state: no open burst, continuation gives nothing (R6, R12)
    step(1,1,1,0,1, 0,0,0,0, "R6");
    step(1,1,1,0,1, 1,0,0,0, "R12");
    // R4: processor strobe read, wr_req ignored
    step(0,1,0,1,0, 1,1,0,0, "R4");
    // R7: driver on after read; continue advance (R6)
    step(1,1,0,1,0, 0,0,0,0, "R7");
    step(1,1,1,0,1, 0,0,0,0, "R6");
    step(1,1,1,0,1, 1,0,1,0, "R9");
    step(1,1,1,0,1, 1,0,0,0, "R7");
    // R10: continuation write forces driver off
    step(1,1,1,0,1, 0,1,0,0, "R10");
    // R3: adsp ignored with ce_n high -> continuation
    step(0,1,1,1,0, 1,0,0,0, "R3");
    step(0,1,1,1,0, 0,0,0,0, "R3");
    // R5: controller strobe write and read
    step(1,0,0,1,0, 1,1,0,0, "R5");
    step(1,0,0,1,0, 1,0,0,0, "R5");
    step(1,1,0,1,0, 1,0,0,0, "R7");
    // R2 / R8: deselect via ce_n high + adsc low
    step(1,0,1,1,0, 1,0,0,0, "R2");
    step(1,1,1,1,0, 0,0,0,0, "R8");
    // R1: wrong chip selects -> deselect
    step(0,1,0,0,0, 1,0,0,0, "R1");
    step(1,0,0,1,1, 1,0,0,0, "R1");
    step(1,0,0,1,0, 1,0,0,0, "R5");
    step(0,1,0,0,0, 1,0,0,0, "R8");
    step(1,1,0,1,0, 0,0,0,0, "R2");
    // R11: sleep freezes state
    step(0,1,0,1,0, 1,0,0,0, "R4");
    step(1,1,0,1,0, 0,0,0,1, "R11");
    step(1,0,1,1,0, 1,0,0,1, "R11");
    step(1,1,0,1,0, 1,0,0,0, "R11");
    step(1,1,0,1,0, 0,0,0,0, "R11");
    // mixed patterns
    for (int i = 0; i < 3000; i++) begin
      bit [9:0] r = 10'($urandom);
      step(r[0] | r[1], r[2] | r[3], r[4] & r[5], ~(r[6] & r[7] & r[8]), r[9] & r[6] & r[5],
           r[1], r[3] ^ r[7], (r[8] & r[0] & r[2]), (r[4] & r[9] & r[1] & r[3]), "R12");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule